// File: doc/BRIEF.md
# Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a small table indexed by low bits of the branch address. Each entry holds two 2-bit saturating counters. A one-bit global history register records the outcome of the most recently resolved branch, and that bit chooses which of the two counters in an entry answers a query. As a result, the same branch can be predicted differently depending on what the branch before it did.

The fetch side presents a PC on the predict port and gets a taken or not-taken answer in the same cycle. The execute side reports each resolved branch on the update port with its PC and its real outcome. The block then trains the counter that the old history selected and loads the outcome into the history register. Target address generation and history repair after a misprediction belong to other blocks.

Top module: `cbp_predictor`

## Requirements
- R1: While rst_ni is low, and right after it is released, every counter holds 01 (weakly not taken) and the history bit is 0 (not taken), so every PC predicts not taken.
- R2: pred_taken_o is the most significant bit of the counter in entry pred_pc_i[5:2] that the current history bit selects. Slot 0 is used after a not-taken branch and slot 1 after a taken branch. Counter values 10 and 11 predict taken, and 00 and 01 predict not taken.
- R3: An update with upd_taken_i = 1 increments the selected counter, and a counter at 11 stays at 11.
- R4: An update with upd_taken_i = 0 decrements the selected counter, and a counter at 00 stays at 00.
- R5: The counter trained by an update is chosen by the history value from before that update. After the update, the history bit equals upd_taken_i.
- R6: An update changes only the counter in entry upd_pc_i[5:2] that the history selects. PC bits outside [5:2] do not affect which entry is used.
- R7: When upd_valid_i is low, no counter and no history bit changes.
- R8: The prediction is combinational from pred_pc_i and the current state. An update presented in a cycle changes predictions only from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_pc_i | input | 32 | PC of the branch being predicted |
| pred_taken_o | output | 1 | 1 when the branch is predicted taken |
| upd_valid_i | input | 1 | A resolved branch is being reported this cycle |
| upd_pc_i | input | 32 | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome of the resolved branch |

## Verification
The vector sequence trains one entry with runs of taken outcomes and then runs of not-taken outcomes, so the counters are driven to both saturation limits. This separates a correct clamp from a counter that wraps around. Alternating outcomes on the same PC make the two slots of one entry diverge, which shows whether the old history or the new history picks the trained slot. Other cases use PCs that differ only above bit 5, an invalid update carrying a taken outcome, and a probe taken in the same cycle as an update. These tell whether indexing, gating and update timing work independently of the counter arithmetic.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
  localparam int unsigned CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_MAX  = '1;
  localparam ctr_t CTR_MIN  = '0;
  localparam ctr_t CTR_INIT = ctr_t'((1 << (CTR_W - 1)) - 1);

  function automatic ctr_t ctr_step(ctr_t v, logic up);
    if (up) return (v == CTR_MAX) ? v : v + ctr_t'(1);
    else    return (v == CTR_MIN) ? v : v - ctr_t'(1);
  endfunction
endpackage

// File: rtl/cbp_sat_ctr.sv
module cbp_sat_ctr
  import cbp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic up_i,
  output ctr_t val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   val_o <= CTR_INIT;
    else if (en_i) val_o <= ctr_step(val_o, up_i);
  end
endmodule

// File: rtl/cbp_history.sv
module cbp_history (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic taken_i,
  output logic hist_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_o <= 1'b0;
    else if (valid_i) hist_o <= taken_i;
  end
endmodule

// File: rtl/cbp_predictor.sv
module cbp_predictor
  import cbp_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned IDX_LSB = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pred_pc_i,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned SLOTS   = 2;

  logic [IDX_W-1:0] pred_idx, upd_idx;
  logic             hist_q;
  logic [ENTRIES-1:0][SLOTS-1:0][CTR_W-1:0] ctr_q;
  logic             unused_pc;

  assign pred_idx  = pred_pc_i[IDX_LSB +: IDX_W];
  assign upd_idx   = upd_pc_i[IDX_LSB +: IDX_W];
  assign unused_pc = ^{pred_pc_i, upd_pc_i};

  cbp_history i_hist (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (upd_valid_i),
    .taken_i (upd_taken_i),
    .hist_o  (hist_q)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic en;
      ctr_t val;
      // slot picked by history before this update
      assign en = upd_valid_i && (upd_idx == IDX_W'(e)) && (hist_q == s[0]);
      cbp_sat_ctr i_ctr (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en),
        .up_i   (upd_taken_i),
        .val_o  (val)
      );
      assign ctr_q[e][s] = val;
    end
  end

  assign pred_taken_o = ctr_q[pred_idx][hist_q][CTR_W-1];
endmodule

// File: rtl/cbp_predictor_chk.sv
module cbp_predictor_chk
  import cbp_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             upd_valid_i,
  input logic             upd_taken_i,
  input logic [IDX_W-1:0] upd_idx,
  input logic             hist_q,
  input logic [(1<<IDX_W)-1:0][1:0][CTR_W-1:0] ctr_q
);
  logic             seen;
  logic             p_valid, p_taken, p_hist;
  logic [IDX_W-1:0] p_idx;
  ctr_t             p_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen <= 1'b0; p_valid <= 1'b0; p_taken <= 1'b0;
      p_hist <= 1'b0; p_idx <= '0; p_val <= '0;
    end else begin
      seen    <= 1'b1;
      p_valid <= upd_valid_i;
      p_taken <= upd_taken_i;
      p_hist  <= hist_q;
      p_idx   <= upd_idx;
      p_val   <= ctr_q[upd_idx][hist_q];
    end
  end

  // R3
  inc_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && p_valid && p_taken |->
      ctr_q[p_idx][p_hist] == ((p_val == CTR_MAX) ? CTR_MAX : p_val + ctr_t'(1)));

  // R4
  dec_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && p_valid && !p_taken |->
      ctr_q[p_idx][p_hist] == ((p_val == CTR_MIN) ? CTR_MIN : p_val - ctr_t'(1)));

  // R5
  hist_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> hist_q == $past(upd_taken_i));

  // R7
  idle_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(hist_q) && $stable(ctr_q));

  // R6
  one_ctr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> $countones(ctr_q ^ $past(ctr_q)) <= CTR_W);
endmodule

bind cbp_predictor cbp_predictor_chk #(.IDX_W(IDX_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .upd_valid_i (upd_valid_i),
  .upd_taken_i (upd_taken_i),
  .upd_idx     (upd_idx),
  .hist_q      (hist_q),
  .ctr_q       (ctr_q)
);

// File: tb/test_cbp_predictor.sv
`timescale 1ns/1ps
module test_cbp_predictor;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pred_pc_i = '0;
  logic        pred_taken_o;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_taken_i = 1'b0;

  int n_cmp = 0;
  int n_mis = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  cbp_predictor i_cbp_predictor (
    .clk_i, .rst_ni, .pred_pc_i, .pred_taken_o,
    .upd_valid_i, .upd_pc_i, .upd_taken_i
  );

  typedef struct packed {
    logic        vld;
    logic [31:0] upc;
    logic        tkn;
    logic [31:0] ppc;
    logic        exp;
  } vec_t;

  // Expected prediction after each update; idx = pc[5:2], slot = history
  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h10,   1'b1, 32'h10, 1'b0}, // [4][0]=10, h=1 -> [4][1]=01 (R5)
    '{1'b1, 32'h10,   1'b1, 32'h10, 1'b1}, // [4][1]=10
    '{1'b1, 32'h20,   1'b0, 32'h10, 1'b1}, // [8][1]=00, h=0 -> [4][0]=10 (R6)
    '{1'b1, 32'h10,   1'b1, 32'h10, 1'b1}, // [4][0]=11, h=1
    '{1'b1, 32'h10,   1'b1, 32'h10, 1'b1}, // [4][1]=11
    '{1'b1, 32'h10,   1'b1, 32'h10, 1'b1}, // [4][1] held at 11 (R3)
    '{1'b1, 32'h10,   1'b0, 32'h10, 1'b1}, // [4][1]=10, h=0 -> [4][0]=11
    '{1'b1, 32'h10,   1'b0, 32'h10, 1'b1}, // [4][0]=10
    '{1'b1, 32'h10,   1'b0, 32'h10, 1'b0}, // [4][0]=01 (R4)
    '{1'b0, 32'h10,   1'b1, 32'h10, 1'b0}, // invalid: nothing moves (R7)
    '{1'b1, 32'h1010, 1'b1, 32'h50, 1'b1}, // upper bits ignored: [4][0]=10, h=1 -> [4][1]=10 (R6)
    '{1'b1, 32'h24,   1'b0, 32'h14, 1'b0}, // [9][1]=00, h=0 -> [5][0]=01
    '{1'b1, 32'h24,   1'b0, 32'h24, 1'b0}, // [9][0]=00
    '{1'b1, 32'h24,   1'b0, 32'h24, 1'b0}, // [9][0] held at 00 (R4)
    '{1'b1, 32'h24,   1'b1, 32'h24, 1'b0}, // [9][0]=01, h=1 -> [9][1]=00
    '{1'b1, 32'h24,   1'b1, 32'h24, 1'b0}, // [9][1]=01
    '{1'b1, 32'h24,   1'b1, 32'h24, 1'b1}  // [9][1]=10 (R2)
  };

  task automatic check(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  endtask

  task automatic scan_reset_state(string req);
    for (int i = 0; i < 16; i++) begin
      pred_pc_i = 32'(i) << 2;
      #1 check(req, pred_taken_o, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_cmp++; n_mis++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    // R1: state held in reset and just after release
    repeat (2) @(negedge clk_i);
    scan_reset_state("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    scan_reset_state("R1 after release");

    // Vector walk covering R2, R3, R4, R5, R6, R7
    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i);
      upd_valid_i = VECS[v].vld;
      upd_pc_i    = VECS[v].upc;
      upd_taken_i = VECS[v].tkn;
      pred_pc_i   = VECS[v].ppc;
      @(negedge clk_i);
      upd_valid_i = 1'b0;
      #1 check($sformatf("R2,R3,R4,R5,R6,R7 vector %0d", v), pred_taken_o, VECS[v].exp);
    end

    // R8: update not visible before the edge, visible after; history is 1 here
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_pc_i = 32'h30; upd_taken_i = 1'b1;
    pred_pc_i   = 32'h30;
    #1 check("R8 before edge", pred_taken_o, 1'b0);
    @(negedge clk_i);
    upd_valid_i = 1'b0;
    #1 check("R8 after edge", pred_taken_o, 1'b1);

    // R2: combinational lookup with history 1
    pred_pc_i = 32'h10; #1 check("R2 entry 4 slot 1", pred_taken_o, 1'b1);
    pred_pc_i = 32'h24; #1 check("R2 entry 9 slot 1", pred_taken_o, 1'b1);
    pred_pc_i = 32'h20; #1 check("R2 entry 8 slot 1", pred_taken_o, 1'b0);

    // R1: reset in mid-run restores every counter and the history
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1 scan_reset_state("R1 mid-run reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    scan_reset_state("R1 after second release");

    finish_run();
  end
endmodule